// File: doc/BRIEF.md
# I2C Control, Interrupt and Pad Multiplexer

This unit is the control register of an I2C master. It holds one 32-bit control word. That word carries the master enable, one interrupt enable per event source, write-one-to-clear strobes and a bit-bang mode. The unit keeps four sticky event flags and merges them into one interrupt line. It also chooses what drives the SCL and SDA pads.

A transfer engine sits beside the unit. The engine reports four kinds of event as single-cycle pulses:
- transfer done
- data service request
- address not acknowledged
- data not acknowledged

The engine also offers its own pad pull-down requests. Software writes the control word and reads back either that word or a status word. The status word holds the flags and the synchronized levels of both pads.

Clearing the master enable resets the interface. It wipes the flags, releases the pads and sends the engine a one-cycle abort pulse, so any byte in flight is dropped. Bit-bang mode cuts the engine off from the pads and drives them straight from two register bits. In those bits a 1 means "pull low".

Top module: `i2c_ctl_unit`

## Requirements
- R1: After reset, the control word reads 0, every flag is 0, `irq` is 0, both pads are released and `engEnable` is 0.
- R2: A write loads the control word. Reading with `rdSel`=0 returns the interrupt enables in bits 31:28, the bit-bang mode in bit 10, SDA drive in bit 7, SCL drive in bit 6 and the master enable in bit 0. All other bits read 0, including the clear strobes in bits 25:22.
- R3: While the master enable is 1, an event pulse sets its sticky flag. Reading with `rdSel`=1 shows the flags in bits 3:0: done in bit 3, data request in bit 2, address NACK in bit 1 and data NACK in bit 0. The enables in bits 31:28 follow the same order.
- R4: Writing 1 to a clear bit clears its flag on the next edge. Bit 25 clears done, bit 24 data request, bit 23 address NACK and bit 22 data NACK. Writing 0 to a clear bit leaves the flag unchanged.
- R5: An event pulse and a clear of the same flag in one cycle leave the flag set.
- R6: `irq` is high exactly when at least one flag is set and its enable is 1. A source whose enable is 0 still sets its flag but does not raise `irq`.
- R7: While the master enable is 0, every flag is 0 and event pulses are ignored. Writing 0 to bit 0 clears all flags on that edge.
- R8: Writing 0 to bit 0 while the master enable is 1 raises `engAbort` for exactly one cycle, starting on that edge. A write of 0 while already disabled gives no pulse.
- R9: The pads are driven as follows (a pull output of 1 pulls the pad low):
  - When the master enable is 0, both pads are released.
  - When enabled with bit 10 at 0, the pads follow `engSclLow` and `engSdaLow`.
  - When enabled with bit 10 at 1, the pads follow bits 6 and 7.
  - `engEnable` is high only when enabled and bit 10 is 0.
- R10: The status word shows the `sclIn` level in bit 4 and the `sdaIn` level in bit 5. Each passes through a two-flop synchronizer, so a pad change is visible after the second clock edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Write data |
| rdSel | input | 1 | Read select: 0 selects the control word, 1 selects the status word |
| rdData | output | 32 | Read data |
| evtDone | input | 1 | Transfer done event pulse |
| evtDataReq | input | 1 | Data service request event pulse |
| evtAddrNack | input | 1 | Address not acknowledged event pulse |
| evtDataNack | input | 1 | Data not acknowledged event pulse |
| engSclLow | input | 1 | Engine request to pull SCL low |
| engSdaLow | input | 1 | Engine request to pull SDA low |
| sclIn | input | 1 | SCL pad level |
| sdaIn | input | 1 | SDA pad level |
| sclPullLow | output | 1 | Pull the SCL pad low |
| sdaPullLow | output | 1 | Pull the SDA pad low |
| engEnable | output | 1 | The engine may run and owns the pads |
| engAbort | output | 1 | One-cycle abort pulse to the engine |
| irq | output | 1 | Interrupt request |

## Verification
A flag stuck at 1 shows at once in two places: on `irq` as soon as its enable is set, and in the status word read right after the event or clear edge. A lost event or a clear that wins over an event shows as a 0 in the status word one edge after the pulse. A wrong enable or bit-bang state shows at the pads in the same cycle, through the pad multiplexer. A wrong synchronizer depth shifts the pad-level bits by a cycle and is caught by sampling after the first and after the second edge.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_SRC    = 4;
  localparam int BIT_EN     = 0;
  localparam int BIT_SCL    = 6;
  localparam int BIT_SDA    = 7;
  localparam int BIT_SW     = 10;
  localparam int BIT_CLR_LO = 22;
  localparam int BIT_IEN_LO = 28;
  localparam int ST_SCL     = NUM_SRC;
  localparam int ST_SDA     = NUM_SRC + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic               load;
    logic               kill;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] set;
  } ctlStrobe_t;
endpackage

// File: rtl/i2c_ctl_ctrl.sv
module i2c_ctl_ctrl
  import i2c_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               enQ,
  output ctlStrobe_t         strb,
  output logic               engAbort
);
  logic unusedCtl;
  assign unusedCtl = ^wrData;

  always_comb begin
    strb      = '0;
    strb.load = wrEn;
    strb.kill = wrEn & ~wrData[BIT_EN];
    strb.clr  = wrEn ? wrData[BIT_CLR_LO +: NUM_SRC] : '0;
    strb.set  = enQ ? evt : '0;
  end

  // abort only when a running interface is switched off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) engAbort <= 1'b0;
    else       engAbort <= enQ & strb.kill;
  end
endmodule

// File: rtl/i2c_ctl_dp.sv
module i2c_ctl_dp
  import i2c_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic [REG_W-1:0]   wrData,
  input  logic               rdSel,
  input  logic               engSclLow,
  input  logic               engSdaLow,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               enQ,
  output logic [NUM_SRC-1:0] flagQ,
  output logic [NUM_SRC-1:0] ienQ,
  output logic [REG_W-1:0]   rdData,
  output logic               sclPullLow,
  output logic               sdaPullLow,
  output logic               engEnable,
  output logic               irq
);
  localparam int SYNC_TOP = SYNC_STAGES - 1;

  logic swQ, sclDrvQ, sdaDrvQ;
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic unusedDp;
  assign unusedDp = ^wrData;

  // control fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      swQ     <= 1'b0;
      sclDrvQ <= 1'b0;
      sdaDrvQ <= 1'b0;
      ienQ    <= '0;
    end else if (strb.load) begin
      enQ     <= wrData[BIT_EN];
      swQ     <= wrData[BIT_SW];
      sclDrvQ <= wrData[BIT_SCL];
      sdaDrvQ <= wrData[BIT_SDA];
      ienQ    <= wrData[BIT_IEN_LO +: NUM_SRC];
    end
  end

  // sticky flags, event wins over clear
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  flagQ[i] <= 1'b0;
      else if (!enQ || strb.kill) flagQ[i] <= 1'b0;
      else                        flagQ[i] <= (flagQ[i] & ~strb.clr[i]) | strb.set[i];
    end
  end

  // pad level synchronizers, idle bus is high
  if (SYNC_STAGES < 2) begin : g_bad
    initial $error("SYNC_STAGES must be at least 2");
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_TOP-1:0], sclIn};
      sdaSync <= {sdaSync[SYNC_TOP-1:0], sdaIn};
    end
  end

  // pad multiplexer
  always_comb begin
    engEnable = enQ & ~swQ;
    if (!enQ) begin
      sclPullLow = 1'b0;
      sdaPullLow = 1'b0;
    end else if (swQ) begin
      sclPullLow = sclDrvQ;
      sdaPullLow = sdaDrvQ;
    end else begin
      sclPullLow = engSclLow;
      sdaPullLow = engSdaLow;
    end
  end

  assign irq = |(flagQ & ienQ);

  // read mux
  always_comb begin
    rdData = '0;
    if (rdSel) begin
      rdData[NUM_SRC-1:0] = flagQ;
      rdData[ST_SCL]      = sclSync[SYNC_TOP];
      rdData[ST_SDA]      = sdaSync[SYNC_TOP];
    end else begin
      rdData[BIT_IEN_LO +: NUM_SRC] = ienQ;
      rdData[BIT_SW]  = swQ;
      rdData[BIT_SDA] = sdaDrvQ;
      rdData[BIT_SCL] = sclDrvQ;
      rdData[BIT_EN]  = enQ;
    end
  end
endmodule

// File: rtl/i2c_ctl_unit.sv
module i2c_ctl_unit
  import i2c_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdSel,
  output logic [REG_W-1:0] rdData,
  input  logic             evtDone,
  input  logic             evtDataReq,
  input  logic             evtAddrNack,
  input  logic             evtDataNack,
  input  logic             engSclLow,
  input  logic             engSdaLow,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclPullLow,
  output logic             sdaPullLow,
  output logic             engEnable,
  output logic             engAbort,
  output logic             irq
);
  ctlStrobe_t         strb;
  logic               enQ;
  logic [NUM_SRC-1:0] flagQ, ienQ;

  i2c_ctl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .evt({evtDone, evtDataReq, evtAddrNack, evtDataNack}),
    .enQ(enQ), .strb(strb), .engAbort(engAbort)
  );

  i2c_ctl_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdSel(rdSel),
    .engSclLow(engSclLow), .engSdaLow(engSdaLow), .sclIn(sclIn), .sdaIn(sdaIn),
    .enQ(enQ), .flagQ(flagQ), .ienQ(ienQ), .rdData(rdData),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow),
    .engEnable(engEnable), .irq(irq)
  );

  logic unusedTop;
  assign unusedTop = ^ienQ;
endmodule

// File: rtl/i2c_ctl_unit_chk.sv
module i2c_ctl_unit_chk
  import i2c_ctl_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [REG_W-1:0]   wrData,
  input logic               evtDone,
  input logic               enQ,
  input logic [NUM_SRC-1:0] flagQ,
  input logic               irq,
  input logic               engAbort,
  input logic               sclPullLow,
  input logic               sdaPullLow
);
  logic unusedChk;
  assign unusedChk = ^wrData;

  // R8
  abort_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    engAbort |=> !engAbort);

  // R7
  off_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> (flagQ == '0));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flagQ != '0));

  // R9
  pads_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |-> (!sclPullLow && !sdaPullLow));

  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && evtDone && wrEn && wrData[BIT_EN] && wrData[BIT_CLR_LO+3]) |=> flagQ[3]);

  // R4
  clear_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && wrEn && wrData[BIT_EN] && wrData[BIT_CLR_LO+3] && !evtDone) |=> !flagQ[3]);
endmodule

bind i2c_ctl_unit i2c_ctl_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .evtDone(evtDone),
  .enQ(enQ), .flagQ(flagQ), .irq(irq), .engAbort(engAbort),
  .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
);

// File: tb/sim_i2c_ctl_unit.sv
`timescale 1ns/1ps
module sim_i2c_ctl_unit;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 1'b0, rdSel = 1'b0;
  logic [31:0] wrData = '0, rdData;
  logic evtDone = 0, evtDataReq = 0, evtAddrNack = 0, evtDataNack = 0;
  logic engSclLow = 0, engSdaLow = 0, sclIn = 1, sdaIn = 1;
  logic sclPullLow, sdaPullLow, engEnable, engAbort, irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  i2c_ctl_unit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdSel(rdSel),
    .rdData(rdData), .evtDone(evtDone), .evtDataReq(evtDataReq),
    .evtAddrNack(evtAddrNack), .evtDataNack(evtDataNack),
    .engSclLow(engSclLow), .engSdaLow(engSdaLow), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow), .engEnable(engEnable),
    .engAbort(engAbort), .irq(irq)
  );

  // {ctrl, engScl, engSda, expScl, expSda, expEngEn}
  localparam logic [36:0] PAD_VEC [8] = '{
    {32'h0000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'h0000_0001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {32'h0000_0401, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {32'h0000_0441, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {32'h0000_0481, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_04C1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {32'h0000_04C0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    evtDone = (which == 3); evtDataReq = (which == 2);
    evtAddrNack = (which == 1); evtDataNack = (which == 0);
    @(negedge clk);
    {evtDone, evtDataReq, evtAddrNack, evtDataNack} = '0;
  endtask

  function automatic logic [31:0] flags();
    return {28'h0, rdData[3:0]};
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdSel = 0; #0 check("R1 ctrl", rdData, 32'h0);
    rdSel = 1; #1 check("R1 flags", flags(), 32'h0);
    check("R1 pads", {30'h0, sclPullLow, sdaPullLow}, 32'h0);
    check("R1 irq/engEnable", {30'h0, irq, engEnable}, 32'h0);

    // R2 readback
    rdSel = 0;
    regWrite(32'hFFFF_FFFF);
    #1 check("R2 readback", rdData, 32'hF000_04C1);
    regWrite(32'h0);

    // R9 pad multiplexer table
    for (int i = 0; i < 8; i++) begin
      regWrite(PAD_VEC[i][36:5]);
      engSclLow = PAD_VEC[i][4]; engSdaLow = PAD_VEC[i][3];
      #1 check("R9 pads", {29'h0, sclPullLow, sdaPullLow, engEnable}, {29'h0, PAD_VEC[i][2:0]});
    end
    engSclLow = 0; engSdaLow = 0;

    // R3 events set flags, R6 disabled source gives no irq
    regWrite(32'h0000_0001);
    rdSel = 1;
    pulse(3);
    #1 check("R3 done flag", flags(), 32'h8);
    check("R6 masked irq", {31'h0, irq}, 32'h0);
    pulse(2); pulse(1); pulse(0);
    #1 check("R3 all flags", flags(), 32'hF);

    // R4 clear all
    regWrite(32'h03C0_0001);
    #1 check("R4 clear all", flags(), 32'h0);

    // R6 irq gating
    pulse(1);
    regWrite(32'h8000_0001);
    #1 check("R6 other enable", {31'h0, irq}, 32'h0);
    regWrite(32'h2000_0001);
    #1 check("R6 matching enable", {31'h0, irq}, 32'h1);

    // R4 zero clear bits keep the flag, one clears it
    regWrite(32'h2000_0001);
    #1 check("R4 zero no effect", flags(), 32'h2);
    regWrite(32'h2080_0001);
    #1 check("R4 clear addr nack", flags(), 32'h0);
    check("R6 irq drops", {31'h0, irq}, 32'h0);

    // R5 event and clear together
    @(negedge clk); wrEn = 1; wrData = 32'h0040_0001; evtDataNack = 1;
    @(negedge clk); wrEn = 0; wrData = '0; evtDataNack = 0;
    #1 check("R5 event wins", flags(), 32'h1);

    // R8 abort pulse, R7 flags wiped
    @(negedge clk); wrEn = 1; wrData = 32'h0;
    @(negedge clk); wrEn = 0;
    #1 check("R8 abort high", {31'h0, engAbort}, 32'h1);
    check("R7 flags wiped", flags(), 32'h0);
    @(negedge clk);
    #1 check("R8 abort one cycle", {31'h0, engAbort}, 32'h0);
    pulse(3);
    #1 check("R7 event ignored", flags(), 32'h0);
    @(negedge clk); wrEn = 1; wrData = 32'h0;
    @(negedge clk); wrEn = 0;
    #1 check("R8 no pulse when idle", {31'h0, engAbort}, 32'h0);

    // R10 synchronizer latency
    @(negedge clk); sclIn = 0; sdaIn = 0;
    @(negedge clk);
    #1 check("R10 after one edge", {30'h0, rdData[5:4]}, 32'h3);
    @(negedge clk);
    #1 check("R10 after two edges", {30'h0, rdData[5:4]}, 32'h0);
    sclIn = 1;
    @(negedge clk); @(negedge clk);
    #1 check("R10 scl alone", {30'h0, rdData[5:4]}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule